// File: doc/BRIEF.md
# Threshold-Pruned Add-Compare-Select Unit

This block extends and prunes the survivor list of a reduced-complexity trellis decoder for a rate-1/2 convolutional code. It keeps a short list of at most `NMAX` live paths, each with its encoder state and accumulated metric. For every received 2-bit hard-decision symbol it grows two children per live path and adds the Hamming distance between the received symbol and the code bits each child would have emitted. Only children whose metric falls below the stage minimum plus a programmable threshold survive. Two children that reach the same trellis state are not merged.

When too many children pass, the block does not sort them. It lowers the working threshold by two and counts again, one cycle per attempt, until the list fits. If a stage would then keep no child at all, the single cheapest child is kept. The survivors are packed into the low rows. Each row reports its state, its metric, the row of its parent and the decision bit. The block also reports which row now holds the smallest metric. Every stored metric is rebased so that the smallest one is zero. A survivor memory outside this block uses the parent pointers, the decision bits and the minimum row.

Top module: `prune_acs`

## Requirements
- R1: The cost of a child is its parent's stored metric plus the number of bit positions in which `symIn` differs from the child's code pair. `symIn[1]` is compared with the bit from generator `G0`, which defaults to 111, and `symIn[0]` with the bit from `G1`, which defaults to 101.
- R2: Row r with state s yields candidate c = 2r+b for input bit b = 0 and b = 1. The code bits are the parities of {b, s} masked by each generator. The child state is {b, s[K-2:1]}, so the newest bit sits in the state MSB.
- R3: With no tightening, a candidate is kept only when its cost is strictly less than `thrNominal`. Stored metrics are rebased so the previous stage minimum is zero, which makes this test the same as a cost below the previous minimum plus the threshold.
- R4: While more than `NMAX` candidates pass, the working threshold drops by 2 (saturating at 0), one cycle per step. Each new symbol restarts from `thrNominal`. With `symValid` sampled at edge e0, `done` is high after edge e(1+r), where r is the number of tightening steps.
- R5: If no candidate passes, exactly one is kept: the lowest-cost valid candidate, with the lowest index winning ties.
- R6: Kept candidates fill rows 0 upward in increasing candidate index. Candidates that reach the same state stay as separate rows. Each row reports its parent row and its decision bit b.
- R7: `minRow` is the first row holding the lowest kept cost. Each stored metric equals its cost minus that lowest cost.
- R8: After reset, row 0 is the only valid row, with state 0, metric 0, parent 0 and decision 0, and `minRow` is 0. `done` is low.
- R9: `done` is a one-cycle pulse. A `symValid` that arrives while a stage is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Strobe that starts a stage with `symIn` |
| symIn | input | 2 | Received hard-decision symbol |
| thrNominal | input | TW | Nominal threshold, loaded at each stage start |
| done | output | 1 | One-cycle pulse when the survivor list is updated |
| survValid | output | NMAX | Row-valid mask |
| survState | output | NMAX*(K-1) | Trellis state per row, row r at bits [r*(K-1) +: K-1] |
| survMetric | output | NMAX*PMW | Rebased metric per row |
| survParent | output | NMAX*RW | Parent row per row |
| survDecision | output | NMAX | Decision bit per row |
| minRow | output | RW | Row holding the lowest metric |

## Verification
For a stage that needs no tightening, the survivor outputs and the `done` pulse appear together one edge after the accepting edge. Each tightening step adds one more edge. The bench drives the strobe at a negative edge and counts negative edges until `done` is seen. It then compares that count with 2 plus the number of tightening steps found by its own model of the stage. It reads all survivor outputs at that same negative edge. It checks at the next negative edge that `done` has fallen. For the ignored strobe, it also waits several more cycles to confirm that no second pulse appears and that the list stays as it was.

// File: rtl/prune_acs_pkg.sv
package prune_acs_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // latch the incoming symbol
    logic commit;  // write the compacted survivor list
  } acsCtrlT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } acsStateT;

endpackage

// File: rtl/prune_acs_bm.sv
// Hamming distance from the received symbol to each of the four code pairs.
module prune_acs_bm #(
  parameter int BMW = 4
) (
  input  logic [1:0]       sym,
  output logic [4*BMW-1:0] bmFlat
);

  generate
    for (genvar code = 0; code < 4; code++) begin : g_code
      localparam logic [1:0] CODE = code[1:0];
      logic [1:0] diff;
      assign diff = sym ^ CODE;
      assign bmFlat[code*BMW +: BMW] = BMW'(diff[1]) + BMW'(diff[0]);
    end
  endgenerate

endmodule

// File: rtl/prune_acs_ctrl.sv
// Stage sequencer: loads the threshold, tightens it, and decides when to commit.
module prune_acs_ctrl
  import prune_acs_pkg::*;
#(
  parameter int NMAX = 4,
  parameter int TW   = 6,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          symValid,
  input  logic [TW-1:0] thrNominal,
  input  logic [CW-1:0] passCount,
  output acsCtrlT       ctrl,
  output logic [TW-1:0] thrCur,
  output logic          done
);

  acsStateT st;

  always_comb begin
    ctrl.load   = (st == ST_IDLE) && symValid;
    ctrl.commit = (st == ST_EVAL) && (passCount <= CW'(NMAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      thrCur <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctrl.commit;
      unique case (st)
        ST_IDLE: begin
          if (symValid) begin
            thrCur <= thrNominal;
            st     <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (ctrl.commit) begin
            st <= ST_IDLE;
          end else begin
            thrCur <= (thrCur >= TW'(2)) ? thrCur - TW'(2) : '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: a retry only happens with too many survivors, so the next threshold is smaller
  a_r4_tighten: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_EVAL && !ctrl.commit) |=> (thrCur < $past(thrCur)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/prune_acs_datapath.sv
// Candidate generation, threshold test, min search, compaction and rebasing.
module prune_acs_datapath
  import prune_acs_pkg::*;
#(
  parameter int             NMAX = 4,
  parameter int             K    = 3,
  parameter logic [K-1:0]   G0   = 3'b111,
  parameter logic [K-1:0]   G1   = 3'b101,
  parameter int             PMW  = 6,
  parameter int             BMW  = 4,
  parameter int             TW   = 6,
  localparam int            SW   = K - 1,
  localparam int            NC   = 2 * NMAX,
  localparam int            RW   = $clog2(NMAX),
  localparam int            CW   = $clog2(NC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  acsCtrlT            ctrl,
  input  logic [1:0]         symIn,
  input  logic [TW-1:0]      thr,
  output logic [CW-1:0]      passCount,
  output logic [NMAX-1:0]    survValid,
  output logic [NMAX*SW-1:0] survState,
  output logic [NMAX*PMW-1:0] survMetric,
  output logic [NMAX*RW-1:0] survParent,
  output logic [NMAX-1:0]    survDecision,
  output logic [RW-1:0]      minRow
);

  localparam int CIW  = $clog2(NC);
  localparam int SUMW = PMW + 1;

  // ---------------- stored survivor list ----------------
  logic [1:0]      symQ;
  logic [NMAX-1:0] validQ, decQ;
  logic [SW-1:0]   stateQ  [NMAX];
  logic [PMW-1:0]  metricQ [NMAX];
  logic [RW-1:0]   parentQ [NMAX];
  logic [RW-1:0]   minRowQ;

  logic [4*BMW-1:0] bmFlat;

  prune_acs_bm #(.BMW(BMW)) u_bm (
    .sym    (symQ),
    .bmFlat (bmFlat)
  );

  // ---------------- candidates ----------------
  logic [SUMW-1:0] candMetric [NC];
  logic [SW-1:0]   candNext   [NC];
  logic [NC-1:0]   candValid, candPass;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_cand
      localparam int ROW = c / 2;
      logic [K-1:0]   regBits;
      logic [1:0]     code;
      logic [BMW-1:0] bmSel;
      assign regBits       = {((c % 2) == 1), stateQ[ROW]};
      assign code          = {^(regBits & G0), ^(regBits & G1)};
      assign bmSel         = bmFlat[int'(code)*BMW +: BMW];
      assign candMetric[c] = {1'b0, metricQ[ROW]} + SUMW'(bmSel);
      assign candNext[c]   = regBits[K-1:1];
      assign candValid[c]  = validQ[ROW];
      assign candPass[c]   = validQ[ROW] && (candMetric[c] < SUMW'(thr));
    end
  endgenerate

  always_comb begin
    passCount = '0;
    for (int c = 0; c < NC; c++) passCount += CW'(candPass[c]);
  end

  // ---------------- lowest-cost valid candidate ----------------
  logic [CIW-1:0]  bestIdx;
  logic [SUMW-1:0] bestMetric;
  logic            bestFound;

  always_comb begin
    bestIdx    = '0;
    bestMetric = '1;
    bestFound  = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (candValid[c] && (!bestFound || candMetric[c] < bestMetric)) begin
        bestFound  = 1'b1;
        bestMetric = candMetric[c];
        bestIdx    = CIW'(c);
      end
    end
  end

  // ---------------- keep set and compaction ----------------
  logic [NC-1:0] keepMask;
  logic [CW-1:0] slot [NC];

  assign keepMask = (passCount == '0) ? (NC'(1) << bestIdx) : candPass;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int c = 0; c < NC; c++) begin
      slot[c] = acc;
      acc     = acc + CW'(keepMask[c]);
    end
  end

  logic [NMAX-1:0] validN, decN;
  logic [SW-1:0]   stateN  [NMAX];
  logic [PMW-1:0]  metricN [NMAX];
  logic [RW-1:0]   parentN [NMAX];
  logic [RW-1:0]   minRowN;

  always_comb begin
    for (int r = 0; r < NMAX; r++) begin
      validN[r]  = 1'b0;
      decN[r]    = 1'b0;
      stateN[r]  = '0;
      metricN[r] = '0;
      parentN[r] = '0;
      for (int c = 0; c < NC; c++) begin
        if (keepMask[c] && slot[c] == CW'(r)) begin
          validN[r]  = 1'b1;
          decN[r]    = (c % 2) == 1;
          stateN[r]  = candNext[c];
          metricN[r] = PMW'(candMetric[c] - bestMetric);
          parentN[r] = RW'(c / 2);
        end
      end
    end
    minRowN = RW'(slot[bestIdx]);
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      symQ    <= '0;
      validQ  <= NMAX'(1);
      decQ    <= '0;
      minRowQ <= '0;
      for (int r = 0; r < NMAX; r++) begin
        stateQ[r]  <= '0;
        metricQ[r] <= '0;
        parentQ[r] <= '0;
      end
    end else begin
      if (ctrl.load) symQ <= symIn;
      if (ctrl.commit) begin
        validQ  <= validN;
        decQ    <= decN;
        minRowQ <= minRowN;
        for (int r = 0; r < NMAX; r++) begin
          stateQ[r]  <= stateN[r];
          metricQ[r] <= metricN[r];
          parentQ[r] <= parentN[r];
        end
      end
    end
  end

  // ---------------- outputs ----------------
  assign survValid    = validQ;
  assign survDecision = decQ;
  assign minRow       = minRowQ;

  generate
    for (genvar r = 0; r < NMAX; r++) begin : g_out
      assign survState[r*SW +: SW]    = stateQ[r];
      assign survMetric[r*PMW +: PMW] = metricQ[r];
      assign survParent[r*RW +: RW]   = parentQ[r];
    end
  endgenerate

  // ---------------- assertions ----------------
  logic [NMAX-1:0] validPrev;
  always_ff @(posedge clk) begin
    if (!rstN) validPrev <= NMAX'(1);
    else       validPrev <= validQ;
  end

  // R7: after a stage, the reported minimum row holds a rebased metric of zero
  a_r7_min_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |=> (metricQ[minRowQ] == '0));

  // R6: live rows are packed from row 0 with no gaps
  a_r6_packed: assert property (@(posedge clk) disable iff (!rstN)
    ((validQ & (validQ + 1'b1)) == '0) && validQ[0]);

  // R5: a stage never leaves an empty list
  a_r5_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |=> (validQ != '0));

  generate
    for (genvar r = 0; r < NMAX; r++) begin : g_chk
      // R6: every new row points at a row that was live before the stage
      a_r6_parent_live: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.commit |=> (!validQ[r] || validPrev[parentQ[r]]));
    end
  endgenerate

endmodule

// File: rtl/prune_acs.sv
module prune_acs
  import prune_acs_pkg::*;
#(
  parameter int           NMAX = 4,
  parameter int           K    = 3,
  parameter logic [K-1:0] G0   = 3'b111,
  parameter logic [K-1:0] G1   = 3'b101,
  parameter int           PMW  = 6,
  parameter int           BMW  = 4,
  parameter int           TW   = 6,
  localparam int          SW   = K - 1,
  localparam int          RW   = $clog2(NMAX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                symValid,
  input  logic [1:0]          symIn,
  input  logic [TW-1:0]       thrNominal,
  output logic                done,
  output logic [NMAX-1:0]     survValid,
  output logic [NMAX*SW-1:0]  survState,
  output logic [NMAX*PMW-1:0] survMetric,
  output logic [NMAX*RW-1:0]  survParent,
  output logic [NMAX-1:0]     survDecision,
  output logic [RW-1:0]       minRow
);

  localparam int CW = $clog2(2 * NMAX + 1);

  acsCtrlT       ctrl;
  logic [TW-1:0] thrCur;
  logic [CW-1:0] passCount;

  prune_acs_ctrl #(.NMAX(NMAX), .TW(TW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .symValid   (symValid),
    .thrNominal (thrNominal),
    .passCount  (passCount),
    .ctrl       (ctrl),
    .thrCur     (thrCur),
    .done       (done)
  );

  prune_acs_datapath #(
    .NMAX(NMAX), .K(K), .G0(G0), .G1(G1), .PMW(PMW), .BMW(BMW), .TW(TW)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .symIn        (symIn),
    .thr          (thrCur),
    .passCount    (passCount),
    .survValid    (survValid),
    .survState    (survState),
    .survMetric   (survMetric),
    .survParent   (survParent),
    .survDecision (survDecision),
    .minRow       (minRow)
  );

endmodule

// File: tb/prune_acs_tb.sv
module prune_acs_tb;

  localparam int NMAX = 4;
  localparam int SW   = 2;
  localparam int PMW  = 6;
  localparam int RW   = 2;
  localparam int TW   = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            symValid = 1'b0;
  logic [1:0]      symIn = '0;
  logic [TW-1:0]   thrNominal = '0;
  logic            done;
  logic [NMAX-1:0] survValid, survDecision;
  logic [NMAX*SW-1:0]  survState;
  logic [NMAX*PMW-1:0] survMetric;
  logic [NMAX*RW-1:0]  survParent;
  logic [RW-1:0]   minRow;

  always #2 clk = ~clk;

  prune_acs u_dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symIn(symIn),
    .thrNominal(thrNominal), .done(done), .survValid(survValid),
    .survState(survState), .survMetric(survMetric), .survParent(survParent),
    .survDecision(survDecision), .minRow(minRow)
  );

  int nChecks = 0;
  int nBad    = 0;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int mValid[NMAX], mState[NMAX], mMetric[NMAX], mParent[NMAX], mDec[NMAX];
  int mMinRow;

  task automatic modelReset();
    for (int r = 0; r < NMAX; r++) begin
      mValid[r] = 0; mState[r] = 0; mMetric[r] = 0; mParent[r] = 0; mDec[r] = 0;
    end
    mValid[0] = 1;
    mMinRow   = 0;
  endtask

  task automatic modelStage(input int sym, input int thr, output int reds);
    int cm[2*NMAX], cn[2*NMAX], cv[2*NMAX], keep[2*NMAX];
    int t, cnt, best, bi, slotN;
    for (int c = 0; c < 2*NMAX; c++) begin
      int row, b, s, s1, s0, o0, o1, x;
      row = c / 2; b = c % 2; s = mState[row];
      s1 = (s >> 1) & 1; s0 = s & 1;
      o0 = b ^ s1 ^ s0;          // generator 111
      o1 = b ^ s0;               // generator 101
      x  = (o0 * 2 + o1) ^ sym;
      cv[c] = mValid[row];
      cm[c] = mMetric[row] + (x & 1) + ((x >> 1) & 1);
      cn[c] = b * 2 + s1;
    end
    t = thr; reds = 0; cnt = 0;
    while (1) begin
      cnt = 0;
      for (int c = 0; c < 2*NMAX; c++) if (cv[c] != 0 && cm[c] < t) cnt++;
      if (cnt > NMAX) begin
        t = (t >= 2) ? t - 2 : 0;
        reds++;
      end else break;
    end
    best = 1000; bi = 0;
    for (int c = 0; c < 2*NMAX; c++)
      if (cv[c] != 0 && cm[c] < best) begin best = cm[c]; bi = c; end
    for (int c = 0; c < 2*NMAX; c++)
      keep[c] = (cnt == 0) ? int'(c == bi) : int'(cv[c] != 0 && cm[c] < t);
    for (int r = 0; r < NMAX; r++) begin
      mValid[r] = 0; mState[r] = 0; mMetric[r] = 0; mParent[r] = 0; mDec[r] = 0;
    end
    slotN = 0;
    for (int c = 0; c < 2*NMAX; c++) begin
      if (keep[c] != 0) begin
        mValid[slotN]  = 1;
        mState[slotN]  = cn[c];
        mMetric[slotN] = cm[c] - best;
        mParent[slotN] = c / 2;
        mDec[slotN]    = c % 2;
        if (c == bi) mMinRow = slotN;
        slotN++;
      end
    end
  endtask

  task automatic compareModel(input string req);
    int mask;
    mask = 0;
    for (int r = 0; r < NMAX; r++) mask |= mValid[r] << r;
    chkEq(req, "valid mask", int'(survValid), mask);
    for (int r = 0; r < NMAX; r++) begin
      if (mValid[r] != 0) begin
        chkEq(req, "state", int'(survState[r*SW +: SW]), mState[r]);
        chkEq(req, "metric", int'(survMetric[r*PMW +: PMW]), mMetric[r]);
        chkEq(req, "parent", int'(survParent[r*RW +: RW]), mParent[r]);
        chkEq(req, "decision", int'(survDecision[r]), mDec[r]);
      end
    end
    chkEq(req, "minRow", int'(minRow), mMinRow);
  endtask

  // ---------------- drivers ----------------
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; symValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // Strobe at e0; count negedges until done. extraAt > 0 re-strobes at that negedge.
  task automatic runStage(input int sym, input int thr, input int extraAt, output int lat);
    @(negedge clk);
    symIn = 2'(sym); thrNominal = TW'(thr); symValid = 1'b1;
    @(posedge clk);
    #1 symValid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (extraAt != 0 && lat == extraAt) begin
        symIn = 2'b11; symValid = 1'b1;
      end else begin
        symValid = 1'b0;
      end
    end while (!done && lat < 60);
    symValid = 1'b0;
  endtask

  task automatic checkDoneFalls(input string req);
    @(negedge clk);
    chkEq(req, "done falls after one cycle", int'(done), 0);
  endtask

  // {rst, sym[1:0], thr[5:0], count[2:0], minRow[1:0], lat[2:0]}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    17'b1_00_001001_010_00_010,  // fresh, two children pass
    17'b0_00_001001_100_00_010,  // four pass
    17'b0_00_001001_010_00_101,  // eight pass, three tightening steps (R4)
    17'b0_00_001001_100_00_010,  // threshold restored at next stage (R4)
    17'b1_11_001001_010_01_010,  // minimum in row 1 (R7)
    17'b0_11_001001_100_10_010,  // rebasing by 1 (R7)
    17'b0_01_000010_100_11_010   // four pass at T=2, minimum last (R3, R6)
  };

  int lat, reds;
  logic [15:0] lfsr;

  initial begin
    rstN = 1'b0;
    doReset();

    // R8: reset state
    chkEq("R8", "done after reset", int'(done), 0);
    chkEq("R8", "valid after reset", int'(survValid), 1);
    chkEq("R8", "state row0", int'(survState[SW-1:0]), 0);
    chkEq("R8", "metric row0", int'(survMetric[PMW-1:0]), 0);
    chkEq("R8", "minRow", int'(minRow), 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16]) doReset();
      modelStage(int'(v[15:14]), int'(v[13:8]), reds);
      runStage(int'(v[15:14]), int'(v[13:8]), 0, lat);
      chkEq("R4", "latency", lat, int'(v[2:0]));
      chkEq("R3", "survivor count", $countones(survValid), int'(v[7:5]));
      chkEq("R7", "minRow from table", int'(minRow), int'(v[4:3]));
      compareModel("R1 R2 R6");
      checkDoneFalls("R9");
    end

    // R3: starting example, T=1, symbol 00: only state 0 with metric 0
    doReset();
    modelStage(0, 1, reds);
    runStage(0, 1, 0, lat);
    chkEq("R3", "example count", $countones(survValid), 1);
    chkEq("R3", "example state", int'(survState[SW-1:0]), 0);
    chkEq("R3", "example metric", int'(survMetric[PMW-1:0]), 0);

    // R3: strict boundary, cost 2 with T=2 is dropped, with T=3 kept
    doReset();
    runStage(0, 2, 0, lat);
    chkEq("R3", "cost equal to T dropped", $countones(survValid), 1);
    doReset();
    runStage(0, 3, 0, lat);
    chkEq("R3", "cost below T kept", $countones(survValid), 2);

    // R5: T=0 keeps the cheapest child only (input 1 child, state 2, cost 0)
    doReset();
    runStage(3, 0, 0, lat);
    chkEq("R5", "fallback count", $countones(survValid), 1);
    chkEq("R5", "fallback state", int'(survState[SW-1:0]), 2);
    chkEq("R5", "fallback decision", int'(survDecision[0]), 1);
    chkEq("R5", "fallback metric", int'(survMetric[PMW-1:0]), 0);
    chkEq("R4", "fallback latency", lat, 2);

    // R9: a strobe during a busy stage is ignored
    doReset();
    modelStage(0, 9, reds); runStage(0, 9, 0, lat);
    modelStage(0, 9, reds); runStage(0, 9, 0, lat);
    modelStage(0, 9, reds);
    runStage(0, 9, 2, lat);
    chkEq("R9", "latency with busy strobe", lat, 2 + reds);
    compareModel("R9");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chkEq("R9", "no second done", int'(done), 0);
    end
    compareModel("R9");

    // pseudo-random walk against the model
    doReset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      int s, t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr[1:0]);
      t = int'(lfsr[7:4]) % 11;
      modelStage(s, t, reds);
      runStage(s, t, 0, lat);
      chkEq("R4", "walk latency", lat, 2 + reds);
      compareModel("R1 R2 R5 R6 R7");
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule